// File: doc/BRIEF.md
# TDM PCM Receive Deserializer and Channel Demultiplexer

This block sits at the receiving end of a time-division multiplexed PCM link. The incoming line has already been squared up into clean logic levels. The block takes that serial stream one bit at a time, whenever the bit enable is high, and shifts it into a serial-in parallel-out register. Each slot carries one sample word of `WORD_W` bits, sent most significant bit first. When the last bit of a slot arrives, the complete word is copied into the holding register of the channel that owns the slot. That channel's update strobe pulses for one cycle. Slots come in fixed round-robin order, channel 0 first.

A frame-sync input lines the receiver up with the transmitter. On a sync the slot counter goes back to channel 0 and the bit counter is cleared. If a sync arrives while a word is only partly received, the partial word is dropped and a misalignment flag pulses for one cycle. Once the last channel of a frame has been received, the block takes no more bits until the next sync. Each holding register keeps its value between updates, so a downstream converter always sees a steady sample.

The controller is a three-state machine:
- `ST_WAIT_SYNC` is the state after reset. No bits are taken in this state.
- `ST_SLOT` collects the words of a frame.
- `ST_HOLD` is entered after the last channel. No bits are taken in this state.

The transitions are:
- "sync": any state goes to `ST_SLOT`, with the slot counter at 0.
- "slot advance": `ST_SLOT` stays in `ST_SLOT`, and the slot counter goes up by one, when a word that is not the last of the frame completes.
- "frame end": `ST_SLOT` goes to `ST_HOLD` when the word of channel `NUM_CH-1` completes.
- "idle": every state stays where it is when there is no sync and no completed word.

Top module: `pcm_tdm_demux`

## Requirements
- R1: After reset, every channel word is 0, every strobe is 0 and `misalign` is 0. Bits that arrive before the first `frame_sync` are ignored and update no channel.
- R2: The first bit accepted after a `frame_sync` is bit `WORD_W-1` of channel 0. The bits of each word arrive MSB first.
- R3: A channel word is released only after all `WORD_W` of its bits have been accepted. On the clock edge that accepts the last bit, `ch_word[c]` takes the new word and `ch_strobe[c]` rises. The strobe stays high for exactly one cycle.
- R4: Slots are assigned round-robin in the order channel 0, 1, … `NUM_CH-1`. Strobe bit `c` (the value `1<<c`) marks channel `c`.
- R5: A channel's holding register keeps its value until that channel's next slot completes. Updates to other channels do not change it.
- R6: A cycle with `bit_en` low is ignored: it neither shifts data nor advances the bit count, whatever `ser_data` holds.
- R7: A `frame_sync` that arrives after 1 to `WORD_W-1` bits of a word discards the partial word. `misalign` is then high for exactly one cycle, starting on the edge that samples the sync. Reception restarts at bit `WORD_W-1` of channel 0.
- R8: A `frame_sync` that arrives on a word boundary does not raise `misalign`.
- R9: After the word of channel `NUM_CH-1` completes, further bits are ignored until the next `frame_sync`.
- R10: A bit presented with `bit_en` high in the same cycle as `frame_sync` is discarded.
- R11: At most one strobe bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Regenerated serial data, MSB first |
| bit_en | input | 1 | High when `ser_data` carries a valid bit |
| frame_sync | input | 1 | Start-of-frame marker; realigns to channel 0 |
| ch_word | output | NUM_CH x WORD_W | Holding register per channel |
| ch_strobe | output | NUM_CH | One-cycle update pulse per channel |
| misalign | output | 1 | One-cycle pulse when a sync cuts a word short |

## Verification
The assertions assume the following about the inputs:
- `frame_sync` is a single-cycle marker.
- A frame never delivers more than `NUM_CH` words before the next sync. Any bits beyond that are expected to be ignored, not counted.
- Within a frame, data is sampled only on `bit_en`.

The stimulus drives every input on the falling edge, so input values are stable at each rising edge. Syncs are applied as single pulses, both at word boundaries and partway through a word. Idle gaps, with `bit_en` low and toggling data, are inserted between bits, so that ignored cycles are exercised inside the rules the assertions rely on.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_SYNC = 2'd0,
        ST_SLOT      = 2'd1,
        ST_HOLD      = 2'd2
    } rx_state_t;
endpackage

// File: rtl/pcm_rx_sipo.sv
// Serial-in parallel-out register with bit counter.
module pcm_rx_sipo #(
    parameter int WORD_W = 8,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              ser_data,
    output logic              word_done,
    output logic [WORD_W-1:0] full_word,
    output logic              partial
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bit_cnt_q;

    assign full_word = {shreg_q[WORD_W-2:0], ser_data};
    assign word_done = shift_en && (bit_cnt_q == LAST_BIT);
    assign partial   = (bit_cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
        end else if (clear) begin
            bit_cnt_q <= '0;
        end else if (shift_en) begin
            shreg_q   <= full_word;
            bit_cnt_q <= word_done ? '0 : bit_cnt_q + 1'b1;
        end
    end

    // R6: idle cycles leave the bit count alone
    p_count_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(bit_cnt_q));

    // R3: count never passes the last bit of a word
    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= LAST_BIT);
endmodule

// File: rtl/pcm_rx_ctrl.sv
// Frame/slot state machine.
module pcm_rx_ctrl
    import pcm_rx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              bit_en,
    input  logic              word_done,
    input  logic              partial,
    output logic              shift_en,
    output logic [SLOT_W-1:0] slot,
    output logic              misalign,
    output rx_state_t         state
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

    rx_state_t         state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              misalign_q, misalign_d;

    assign shift_en = (state_q == ST_SLOT) && bit_en && !frame_sync;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT_SYNC;
            slot_q     <= '0;
            misalign_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            slot_q     <= slot_d;
            misalign_q <= misalign_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        slot_d     = slot_q;
        misalign_d = 1'b0;
        unique case (state_q)
            ST_WAIT_SYNC: begin
                state_d = ST_WAIT_SYNC;
            end
            ST_SLOT: begin
                if (word_done) begin
                    if (slot_q == LAST_SLOT) begin
                        state_d = ST_HOLD;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                state_d = ST_HOLD;
            end
            default: begin
                state_d = ST_WAIT_SYNC;
            end
        endcase
        if (frame_sync) begin
            state_d    = ST_SLOT;
            slot_d     = '0;
            misalign_d = (state_q == ST_SLOT) && partial;
        end
    end

    assign slot     = slot_q;
    assign misalign = misalign_q;
    assign state    = state_q;

    // R7: the misalignment flag is a single-cycle pulse
    p_misalign_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_q |=> !misalign_q);

    // R7: a sync always restarts at channel 0
    p_sync_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (state_q == ST_SLOT) && (slot_q == '0));

    // R4: slots step by one in order
    p_slot_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !frame_sync && slot_q != LAST_SLOT) |=> slot_q == $past(slot_q) + 1'b1);

    // R4: slot index stays in range
    p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_SLOT);
endmodule

// File: rtl/pcm_rx_bank.sv
// Per-channel holding registers and update strobes.
module pcm_rx_bank #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 8,
    parameter int SLOT_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [SLOT_W-1:0]              slot,
    input  logic [WORD_W-1:0]              full_word,
    output logic [NUM_CH-1:0][WORD_W-1:0]  ch_word,
    output logic [NUM_CH-1:0]              ch_strobe
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = load && (slot == SLOT_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_word[i]   <= '0;
                ch_strobe[i] <= 1'b0;
            end else begin
                ch_strobe[i] <= hit;
                if (hit) begin
                    ch_word[i] <= full_word;
                end
            end
        end

        // R5: a channel word only changes together with its strobe
        p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_strobe[i] |-> $stable(ch_word[i]));
    end

    // R11: never more than one channel strobe
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_strobe));
endmodule

// File: rtl/pcm_tdm_demux.sv
module pcm_tdm_demux
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_data,
    input  logic                          bit_en,
    input  logic                          frame_sync,
    output logic [NUM_CH-1:0][WORD_W-1:0] ch_word,
    output logic [NUM_CH-1:0]             ch_strobe,
    output logic                          misalign
);
    localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              shift_en;
    logic              word_done;
    logic              partial;
    logic [WORD_W-1:0] full_word;
    logic [SLOT_W-1:0] slot;
    rx_state_t         state;

    pcm_rx_ctrl #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bit_en(bit_en),
        .word_done(word_done), .partial(partial), .shift_en(shift_en),
        .slot(slot), .misalign(misalign), .state(state)
    );

    pcm_rx_sipo #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_sipo (
        .clk(clk), .rst_n(rst_n), .clear(frame_sync), .shift_en(shift_en),
        .ser_data(ser_data), .word_done(word_done), .full_word(full_word),
        .partial(partial)
    );

    pcm_rx_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(word_done), .slot(slot),
        .full_word(full_word), .ch_word(ch_word), .ch_strobe(ch_strobe)
    );

    // R3: a strobe follows a cycle that accepted a bit
    p_strobe_needs_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_strobe) |-> ($past(bit_en) && !$past(frame_sync)));

    // R9: once the frame is complete, no strobe until a new sync
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !frame_sync) |=> (ch_strobe == '0));

    // R7: misalignment only follows a sync
    p_misalign_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> $past(frame_sync));
endmodule

// File: tb/pcm_tdm_demux_bench.sv
module pcm_tdm_demux_bench;
    localparam int W = 8;
    localparam int C = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0;
    logic bit_en = 1'b0;
    logic frame_sync = 1'b0;
    logic [C-1:0][W-1:0] ch_word;
    logic [C-1:0] ch_strobe;
    logic misalign;

    int total = 0;
    int fails = 0;
    logic [W-1:0] exp_w [C];

    always #2 clk = ~clk;

    pcm_tdm_demux #(.WORD_W(W), .NUM_CH(C)) u_pcm_tdm_demux (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .bit_en(bit_en),
        .frame_sync(frame_sync), .ch_word(ch_word), .ch_strobe(ch_strobe),
        .misalign(misalign)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // drive on falling edge, sample just after the rising edge
    task automatic put(input logic fs, input logic en, input logic d);
        @(negedge clk);
        frame_sync = fs;
        bit_en     = en;
        ser_data   = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_all(input string tag);
        for (int c = 0; c < C; c++) chk(tag, "held word", ch_word[c], exp_w[c]);
    endtask

    task automatic send_word(input string tag, input int ch,
                             input logic [W-1:0] val, input int gap);
        for (int b = W - 1; b >= 0; b--) begin
            put(1'b0, 1'b1, val[b]);
            if (b != 0) begin
                chk("R3", "no strobe before last bit", ch_strobe, 0);
                for (int g = 0; g < gap; g++) put(1'b0, 1'b0, ~val[b]);
            end
        end
        chk(tag, "strobe onehot R4 R11", ch_strobe, 1 << ch);
        chk(tag, "word R2", ch_word[ch], val);
        exp_w[ch] = val;
        chk_all("R5");
        put(1'b0, 1'b0, 1'b0);
        chk("R3", "strobe one cycle", ch_strobe, 0);
    endtask

    task automatic t_reset;
        chk("R1", "strobe at reset", ch_strobe, 0);
        chk("R1", "misalign at reset", misalign, 0);
        chk_all("R1");
        for (int b = 0; b < 2 * W; b++) begin
            put(1'b0, 1'b1, 1'b1);
            chk("R1", "no strobe before sync", ch_strobe, 0);
        end
        chk_all("R1");
    endtask

    task automatic t_frame;
        put(1'b1, 1'b0, 1'b0);
        chk("R8", "sync from wait state", misalign, 0);
        send_word("R4", 0, 8'hA5, 0);
        send_word("R4", 1, 8'h3C, 0);
        send_word("R4", 2, 8'hF0, 0);
        send_word("R4", 3, 8'h0F, 0);
    endtask

    task automatic t_idle_and_hold;
        put(1'b1, 1'b0, 1'b0);
        send_word("R6", 0, 8'h69, 2);
        chk("R5", "ch3 unchanged", ch_word[3], 8'h0F);
        chk("R5", "ch2 unchanged", ch_word[2], 8'hF0);
        send_word("R6", 1, 8'h81, 1);
    endtask

    task automatic t_misalign;
        put(1'b1, 1'b0, 1'b0);
        put(1'b0, 1'b1, 1'b1);
        put(1'b0, 1'b1, 1'b0);
        put(1'b0, 1'b1, 1'b1);
        put(1'b1, 1'b0, 1'b0);
        chk("R7", "misalign raised", misalign, 1);
        chk("R7", "no strobe on sync", ch_strobe, 0);
        put(1'b0, 1'b0, 1'b0);
        chk("R7", "misalign one cycle", misalign, 0);
        chk_all("R7");
        send_word("R7", 0, 8'h96, 0);
        put(1'b1, 1'b0, 1'b0);
        chk("R8", "sync on word boundary", misalign, 0);
        send_word("R8", 0, 8'h12, 0);
    endtask

    task automatic t_after_last;
        put(1'b1, 1'b0, 1'b0);
        send_word("R9", 0, 8'h11, 0);
        send_word("R9", 1, 8'h22, 0);
        send_word("R9", 2, 8'h44, 0);
        send_word("R9", 3, 8'h88, 0);
        for (int b = 0; b < 2 * W; b++) begin
            put(1'b0, 1'b1, b[0]);
            chk("R9", "no strobe after last channel", ch_strobe, 0);
        end
        chk_all("R9");
    endtask

    task automatic t_sync_bit;
        put(1'b1, 1'b1, 1'b1);
        send_word("R10", 0, 8'h0F, 0);
        send_word("R10", 1, 8'hC3, 0);
    endtask

    initial begin
        for (int c = 0; c < C; c++) exp_w[c] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_frame;
        t_idle_and_hold;
        t_misalign;
        t_after_last;
        t_sync_bit;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule